// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns a 32-bit linear address into a physical address. It reads a page directory and a page table, each with 1024 four-byte entries, from memory over a single-beat read/write port. A small direct-mapped translation cache sits in front of the walker. A request that hits in the cache, or that arrives while paging is off, is answered one cycle after it is accepted and makes no memory access.

On a miss the walker reads the directory entry and then the table entry. Before it moves on from either level, it writes an entry back to memory if that entry's accessed flag needs setting, or, for a write access, if the table entry's dirty flag needs setting. The writable and user permissions of the two levels are ANDed together. When checking is enabled, the result is tested against the caller's privilege level and the write-protect control. A failed test gives a page fault with a three-bit error code and stores the faulting linear address.

The block handles one translation at a time. A flush input clears the whole cache.

Top module: `xlat_walker`

## Requirements
- R1: While `pagingEn` is low, an accepted request returns `rspPhys` equal to the linear address with `rspFault` low. `rspValid` rises one cycle after acceptance and no memory access is made.
- R2: Entry bit positions are: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bits 31:12 frame. The directory entry is read at `dirBase` + 4 × lin[31:22]. The table entry is read at (directory frame << 12) + 4 × lin[21:12]. `rspPhys` is the table frame joined with lin[11:0].
- R3: A present directory entry whose accessed bit is clear is written back with that bit set, before the table entry is read. A directory entry whose accessed bit is already set is not written.
- R4: A present table entry is written back only if its accessed bit was clear, or if the access is a write and its dirty bit was clear. The value written has accessed set, and has dirty set only for writes.
- R5: A directory or table entry with its present bit clear ends the walk. The result is the all-zero entry: present, writable and user are 0, and `rspPhys` is lin[11:0] with zero above it.
- R6: `rspWritable` is the AND of the writable bits of both levels. `rspUser` is the AND of the user bits of both levels.
- R7: With `reqCheck` high, a fault is raised in any of three cases: the page is not present; the page is not user-accessible and the privilege level is nonzero; or the access is a write, `wrProt` is high and the page is not writable. With `reqCheck` low, no fault is raised.
- R8: On a fault, `rspErr` bit 0 is the present bit, bit 1 is the write flag and bit 2 is set for a nonzero privilege level. From the next cycle, `faultAddr` holds the faulting linear address.
- R9: When `reqV86` is high, the privilege level used for checks and for the error code is 3, whatever `reqCpl` is.
- R10: The cache holds 16 entries. It is indexed by lin[15:12] and tagged by lin[31:16]. A hit answers one cycle after acceptance with no memory access. Not-present results are never cached. Two pages with the same index evict each other.
- R11: `flush` invalidates every cache entry. A request accepted in the same cycle as `flush` is treated as a miss.
- R12: `memReq` is held with stable address, write flag and data until `memAck`. `busy` is high from the cycle after acceptance through the `rspValid` cycle. `rspValid` is a single-cycle pulse and nothing is accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translate request, accepted when `busy` is low |
| reqLin | input | 32 | Linear address to translate |
| reqWrite | input | 1 | Access is a write |
| reqCheck | input | 1 | Enable permission checks |
| reqCpl | input | 2 | Current privilege level |
| reqV86 | input | 1 | Force privilege level 3 for checks |
| dirBase | input | 32 | Page directory base address |
| pagingEn | input | 1 | Paging enabled |
| wrProt | input | 1 | Non-writable pages fault on writes |
| flush | input | 1 | Invalidate the translation cache |
| busy | output | 1 | Translation in progress |
| rspValid | output | 1 | Result valid (one-cycle pulse) |
| rspPhys | output | 32 | Physical address |
| rspWritable | output | 1 | Effective writable permission |
| rspUser | output | 1 | Effective user permission |
| rspFault | output | 1 | Page fault |
| rspErr | output | 3 | Fault error code |
| faultAddr | output | 32 | Last faulting linear address |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory address |
| memWdata | output | 32 | Memory write data |
| memAck | input | 1 | Memory request complete |
| memRdata | input | 32 | Memory read data |

## Verification
A stale or mis-tagged cache line shows up on the very next `rspValid` as a wrong `rspPhys` or wrong permissions with no memory traffic. A cache that fails to hit shows up as extra memory reads. A wrong walk state shows up at the memory port within one access: the directory or table address is wrong, a write-back is missing or extra, or an accessed or dirty bit is wrong in the stored entry. The bench counts reads and writes per translation and inspects the memory image after each one. A wrong latched request field shows up as a wrong fault decision or error code in the same response, or as a wrong `faultAddr` one cycle later.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int OFF_W = 12;
  localparam int IDX_LVL_W = 10;
  localparam int BIT_P = 0;
  localparam int BIT_W = 1;
  localparam int BIT_U = 2;
  localparam int BIT_A = 5;
  localparam int BIT_D = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_PDE, ST_WB_PDE, ST_RD_PTE, ST_WB_PTE, ST_DONE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic ldPde;
    logic ldPte;
    logic ldZero;
    logic memReq;
    logic memWe;
    logic selPte;
    logic done;
  } walkStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic fastPath;
    logic rdPresent;
    logic rdAccessed;
    logic pteNeedWb;
  } walkStatus_t;

  // cached effective translation
  typedef struct packed {
    logic [31:OFF_W] frame;
    logic user;
    logic wr;
    logic pres;
  } xlatEnt_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memAck,
  input  walkStatus_t st,
  output walkStrobe_t sb,
  output walkState_t  stateOut
);
  walkState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    sb  = '0;
    nxt = state;
    case (state)
      ST_IDLE: if (reqValid) begin
        sb.accept = 1'b1;
        nxt = st.fastPath ? ST_DONE : ST_RD_PDE;
      end
      ST_RD_PDE: begin
        sb.memReq = 1'b1;
        if (memAck) begin
          sb.ldPde = 1'b1;
          if (!st.rdPresent) begin
            sb.ldZero = 1'b1;
            nxt = ST_DONE;
          end else begin
            nxt = st.rdAccessed ? ST_RD_PTE : ST_WB_PDE;
          end
        end
      end
      ST_WB_PDE: begin
        sb.memReq = 1'b1;
        sb.memWe  = 1'b1;
        if (memAck) nxt = ST_RD_PTE;
      end
      ST_RD_PTE: begin
        sb.memReq = 1'b1;
        sb.selPte = 1'b1;
        if (memAck) begin
          if (!st.rdPresent) begin
            sb.ldZero = 1'b1;
            nxt = ST_DONE;
          end else begin
            sb.ldPte = 1'b1;
            nxt = st.pteNeedWb ? ST_WB_PTE : ST_DONE;
          end
        end
      end
      ST_WB_PTE: begin
        sb.memReq = 1'b1;
        sb.memWe  = 1'b1;
        sb.selPte = 1'b1;
        if (memAck) nxt = ST_DONE;
      end
      ST_DONE: begin
        sb.done = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign stateOut = state;
endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
#(
  parameter int TLB_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  walkStrobe_t sb,
  input  logic        flush,
  input  logic        pagingEn,
  input  logic        wrProt,
  input  logic [31:0] reqLin,
  input  logic        reqWrite,
  input  logic        reqCheck,
  input  logic [1:0]  reqCpl,
  input  logic        reqV86,
  input  logic [31:0] dirBase,
  input  logic [31:0] memRdata,
  output walkStatus_t st,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [31:0] rspPhys,
  output logic        rspWritable,
  output logic        rspUser,
  output logic        rspFault,
  output logic [2:0]  rspErr,
  output logic [31:0] faultAddr
);
  localparam int IDX_W = $clog2(TLB_DEPTH);
  localparam int TAG_W = 32 - OFF_W - IDX_W;

  logic [31:0] linReg, pdeReg, pteWb;
  logic        wrReg, chkReg, wpReg, bypReg;
  logic [1:0]  cplReg;
  xlatEnt_t    entReg, walkEnt;

  logic [TLB_DEPTH-1:0] tlbValid;
  logic                 tlbEmpty;
  logic [TAG_W-1:0]     tlbTag  [TLB_DEPTH];
  xlatEnt_t             tlbData [TLB_DEPTH];

  logic [IDX_W-1:0] reqIdx, linIdx;
  logic [TAG_W-1:0] reqTag;
  logic             tlbHit, faultCond;

  assign reqIdx = reqLin[OFF_W +: IDX_W];
  assign reqTag = reqLin[31 -: TAG_W];
  assign linIdx = linReg[OFF_W +: IDX_W];
  assign tlbHit = tlbValid[reqIdx] && (tlbTag[reqIdx] == reqTag) && !flush;

  assign st.fastPath   = !pagingEn || tlbHit;
  assign st.rdPresent  = memRdata[BIT_P];
  assign st.rdAccessed = memRdata[BIT_A];
  assign st.pteNeedWb  = !memRdata[BIT_A] || (wrReg && !memRdata[BIT_D]);

  // effective entry built from the table entry being read and the held directory entry
  always_comb begin
    walkEnt.frame = memRdata[31:OFF_W];
    walkEnt.pres  = 1'b1;
    walkEnt.wr    = memRdata[BIT_W] & pdeReg[BIT_W];
    walkEnt.user  = memRdata[BIT_U] & pdeReg[BIT_U];
  end

  always_comb begin
    if (sb.selPte) begin
      memAddr  = {pdeReg[31:OFF_W], linReg[OFF_W +: IDX_LVL_W], 2'b00};
      memWdata = pteWb;
    end else begin
      memAddr  = dirBase + {20'd0, linReg[31 -: IDX_LVL_W], 2'b00};
      memWdata = pdeReg | (32'd1 << BIT_A);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linReg <= '0; wrReg <= 1'b0; chkReg <= 1'b0; wpReg <= 1'b0;
      bypReg <= 1'b1; cplReg <= '0; pdeReg <= '0; pteWb <= '0;
      entReg <= '0; faultAddr <= '0;
    end else begin
      if (sb.accept) begin
        linReg <= reqLin;
        wrReg  <= reqWrite;
        chkReg <= reqCheck;
        wpReg  <= wrProt;
        bypReg <= !pagingEn;
        cplReg <= reqV86 ? 2'd3 : reqCpl;
        entReg <= tlbData[reqIdx];
      end
      if (sb.ldPde) pdeReg <= memRdata;
      if (sb.ldPte) begin
        pteWb  <= memRdata | (32'd1 << BIT_A) | (wrReg ? (32'd1 << BIT_D) : 32'd0);
        entReg <= walkEnt;
      end
      if (sb.ldZero) entReg <= '0;
      if (sb.done && faultCond) faultAddr <= linReg;
    end
  end

  // translation cache: flush wins over a fill in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlbValid <= '0;
      tlbEmpty <= 1'b1;
    end else if (flush) begin
      if (!tlbEmpty) begin
        tlbValid <= '0;
        tlbEmpty <= 1'b1;
      end
    end else if (sb.ldPte) begin
      tlbValid[linIdx] <= 1'b1;
      tlbEmpty <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (sb.ldPte) begin
      tlbTag[linIdx]  <= linReg[31 -: TAG_W];
      tlbData[linIdx] <= walkEnt;
    end
  end

  assign faultCond = !bypReg && chkReg &&
                     (!entReg.pres || (!entReg.user && cplReg != 2'd0) ||
                      (wrReg && wpReg && !entReg.wr));
  assign rspPhys     = bypReg ? linReg : {entReg.frame, linReg[OFF_W-1:0]};
  assign rspWritable = bypReg | entReg.wr;
  assign rspUser     = bypReg | entReg.user;
  assign rspFault    = sb.done && faultCond;
  assign rspErr      = rspFault ? {cplReg != 2'd0, wrReg, entReg.pres} : 3'b000;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int TLB_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqLin,
  input  logic        reqWrite,
  input  logic        reqCheck,
  input  logic [1:0]  reqCpl,
  input  logic        reqV86,
  input  logic [31:0] dirBase,
  input  logic        pagingEn,
  input  logic        wrProt,
  input  logic        flush,
  output logic        busy,
  output logic        rspValid,
  output logic [31:0] rspPhys,
  output logic        rspWritable,
  output logic        rspUser,
  output logic        rspFault,
  output logic [2:0]  rspErr,
  output logic [31:0] faultAddr,
  output logic        memReq,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memAck,
  input  logic [31:0] memRdata
);
  walkStrobe_t sb;
  walkStatus_t st;
  walkState_t  state;

  xlat_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memAck(memAck),
    .st(st), .sb(sb), .stateOut(state)
  );

  xlat_dpath #(.TLB_DEPTH(TLB_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .sb(sb), .flush(flush), .pagingEn(pagingEn),
    .wrProt(wrProt), .reqLin(reqLin), .reqWrite(reqWrite), .reqCheck(reqCheck),
    .reqCpl(reqCpl), .reqV86(reqV86), .dirBase(dirBase), .memRdata(memRdata),
    .st(st), .memAddr(memAddr), .memWdata(memWdata), .rspPhys(rspPhys),
    .rspWritable(rspWritable), .rspUser(rspUser), .rspFault(rspFault),
    .rspErr(rspErr), .faultAddr(faultAddr)
  );

  assign busy     = (state != ST_IDLE);
  assign rspValid = (state == ST_DONE);
  assign memReq   = sb.memReq;
  assign memWe    = sb.memWe;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        busy,
  input logic        rspValid,
  input logic        memReq,
  input logic        memWe,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata
);
  assert_mem_in_walk_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R3 and R4: every write-back carries the accessed bit
  assert_wb_accessed_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> memWdata[5]);

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid && !busy);

  assert_accept_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqValid |=> busy);
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqCheck = 1'b0, reqV86 = 1'b0;
  logic [31:0] reqLin = '0;
  logic [1:0] reqCpl = '0;
  logic [31:0] dirBase = 32'h0001_0000;
  logic pagingEn = 1'b1, wrProt = 1'b0, flush = 1'b0;
  logic busy, rspValid, rspWritable, rspUser, rspFault, memReq, memWe;
  logic [31:0] rspPhys, faultAddr, memAddr, memWdata;
  logic [2:0] rspErr;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int nChecks = 0, nErr = 0, nRd = 0, nWr = 0;
  logic [31:0] memArr [logic [31:0]];

  logic [31:0] rPhys, rFaultAddr;
  logic rW, rU, rFault;
  logic [2:0] rErr;
  int rLat;

  always #10 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLin(reqLin),
    .reqWrite(reqWrite), .reqCheck(reqCheck), .reqCpl(reqCpl), .reqV86(reqV86),
    .dirBase(dirBase), .pagingEn(pagingEn), .wrProt(wrProt), .flush(flush),
    .busy(busy), .rspValid(rspValid), .rspPhys(rspPhys), .rspWritable(rspWritable),
    .rspUser(rspUser), .rspFault(rspFault), .rspErr(rspErr), .faultAddr(faultAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] rdMem(input logic [31:0] a);
    return memArr.exists(a) ? memArr[a] : 32'd0;
  endfunction

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        memArr[memAddr] = memWdata;
        nWr++;
      end else begin
        memRdata <= rdMem(memAddr);
        nRd++;
      end
    end else memAck <= 1'b0;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xlat(input logic [31:0] lin, input logic wr, input logic chk,
                      input logic [1:0] cpl, input logic v86, input logic doFlush);
    @(negedge clk);
    nRd = 0; nWr = 0;
    reqValid = 1'b1; reqLin = lin; reqWrite = wr; reqCheck = chk;
    reqCpl = cpl; reqV86 = v86; flush = doFlush;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; flush = 1'b0;
    rLat = 1;
    while (!rspValid) begin
      if (!busy) check("R12", "busy during walk", {31'd0, busy}, 32'd1);
      @(negedge clk);
      rLat++;
    end
    check("R12", "busy with result", {31'd0, busy}, 32'd1);
    rPhys = rspPhys; rW = rspWritable; rU = rspUser; rFault = rspFault; rErr = rspErr;
    @(negedge clk);
    rFaultAddr = faultAddr;
    check("R12", "idle after result", {30'd0, busy, rspValid}, 32'd0);
  endtask

  task automatic flushOnly();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    check("R12", "reset outputs", {29'd0, busy, rspValid, memReq}, 32'd0);
  endtask

  task automatic t_bypass();
    pagingEn = 1'b0;
    xlat(32'h1234_5678, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0);
    check("R1", "bypass phys", rPhys, 32'h1234_5678);
    check("R1", "bypass fault", {31'd0, rFault}, 32'd0);
    check("R1", "bypass latency", rLat, 1);
    check("R1", "bypass mem ops", nRd + nWr, 0);
    pagingEn = 1'b1;
  endtask

  task automatic t_walkRead();
    memArr[32'h0001_0004] = 32'h0002_0007;
    memArr[32'h0002_000C] = 32'h0ABC_D007;
    xlat(32'h0040_3ABC, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0);
    check("R2", "walk phys", rPhys, 32'h0ABC_DABC);
    check("R2", "walk perms", {30'd0, rW, rU}, 32'd3);
    check("R3", "pde accessed written", rdMem(32'h0001_0004), 32'h0002_0027);
    check("R4", "pte accessed, no dirty on read", rdMem(32'h0002_000C), 32'h0ABC_D027);
    check("R4", "write-back count", nWr, 2);
    check("R2", "read count", nRd, 2);
  endtask

  task automatic t_hit();
    xlat(32'h0040_3ABC, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0);
    check("R10", "hit phys", rPhys, 32'h0ABC_DABC);
    check("R10", "hit latency", rLat, 1);
    check("R10", "hit mem ops", nRd + nWr, 0);
  endtask

  task automatic t_dirty();
    memArr[32'h0002_0010] = 32'h0BEE_F027;
    xlat(32'h0040_4010, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R3", "no pde write when accessed set", nWr, 1);
    check("R4", "pte dirty set on write", rdMem(32'h0002_0010), 32'h0BEE_F067);
    check("R2", "phys", rPhys, 32'h0BEE_F010);
    memArr[32'h0002_0014] = 32'h0C0D_E067;
    xlat(32'h0040_5000, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R4", "no write when accessed and dirty set", nWr, 0);
  endtask

  task automatic t_permAnd();
    memArr[32'h0001_0008] = 32'h0002_1025;
    memArr[32'h0002_1000] = 32'h0D00_D027;
    xlat(32'h0080_0000, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0);
    check("R6", "writable and-ed", {31'd0, rW}, 32'd0);
    check("R6", "user and-ed", {31'd0, rU}, 32'd1);
    check("R7", "read of user page no fault", {31'd0, rFault}, 32'd0);
    wrProt = 1'b1;
    xlat(32'h0080_0123, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R7", "write-protect fault", {31'd0, rFault}, 32'd1);
    check("R8", "error code", {29'd0, rErr}, 32'd3);
    check("R8", "fault address", rFaultAddr, 32'h0080_0123);
    wrProt = 1'b0;
    xlat(32'h0080_0124, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R7", "no fault without write protect", {31'd0, rFault}, 32'd0);
  endtask

  task automatic t_supervisor();
    memArr[32'h0001_000C] = 32'h0002_2023;
    memArr[32'h0002_2000] = 32'h0E0E_0027;
    xlat(32'h00C0_0010, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R7", "level 0 on supervisor page", {31'd0, rFault}, 32'd0);
    check("R2", "phys", rPhys, 32'h0E0E_0010);
    xlat(32'h00C0_0020, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0);
    check("R7", "level 2 on supervisor page", {31'd0, rFault}, 32'd1);
    check("R8", "error code", {29'd0, rErr}, 32'd5);
    xlat(32'h00C0_0030, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0);
    check("R9", "v86 forces level 3", {28'd0, rFault, rErr}, 32'hD);
    xlat(32'h00C0_0040, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0);
    check("R7", "no fault with checks off", {31'd0, rFault}, 32'd0);
  endtask

  task automatic t_notPresent();
    memArr[32'h0001_0010] = 32'h0;
    xlat(32'h0100_0777, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R5", "pde absent reads", nRd, 1);
    check("R5", "pde absent phys", rPhys, 32'h0000_0777);
    check("R8", "absent error code", {28'd0, rFault, rErr}, 32'h8);
    check("R8", "absent fault address", rFaultAddr, 32'h0100_0777);
    memArr[32'h0001_0014] = 32'h0002_3021;
    memArr[32'h0002_3000] = 32'h0;
    xlat(32'h0140_0008, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
    check("R5", "pte absent ops", {nRd[15:0], nWr[15:0]}, {16'd2, 16'd0});
    check("R8", "pte absent error code", {28'd0, rFault, rErr}, 32'hE);
    xlat(32'h0140_0008, 1'b1, 1'b1, 2'd1, 1'b0, 1'b0);
    check("R10", "absent not cached", nRd, 2);
  endtask

  task automatic t_flush();
    flushOnly();
    xlat(32'h0040_3ABC, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0);
    check("R11", "walk after flush", {nRd[15:0], nWr[15:0]}, {16'd2, 16'd0});
    check("R11", "phys after flush", rPhys, 32'h0ABC_DABC);
    xlat(32'h0040_4010, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R11", "refill", nRd, 2);
    xlat(32'h0040_4010, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1);
    check("R11", "flush with request misses", nRd, 2);
  endtask

  task automatic t_conflict();
    memArr[32'h0002_004C] = 32'h0F00_F027;
    xlat(32'h0041_3000, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R10", "conflicting page walks", nRd, 2);
    check("R10", "conflicting page phys", rPhys, 32'h0F00_F000);
    xlat(32'h0040_3ABC, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R10", "evicted page walks", nRd, 2);
    xlat(32'h0040_3ABC, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0);
    check("R10", "refilled page hits", nRd + nWr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_walkRead();
    t_hit();
    t_dirty();
    t_permAnd();
    t_supervisor();
    t_notPresent();
    t_flush();
    t_conflict();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule